// File: doc/BRIEF.md
# Bidirectional-Bus Universal Shift Register

This block is a parameterised universal shift register, eight bits wide by default. A two-bit mode input selects one of four operations: hold, shift toward the high end, shift toward the low end, or parallel load. Every operation takes effect on the rising clock edge. The register has a serial input at each end. Each end bit also drives its own serial output, and those two outputs are never disabled.

The parallel lines are meant to be a shared bus. They carry data into the register during a load and drive the register contents out at all other times. The core splits that bus into three separate ports: `bus_in`, `bus_out` and `bus_oe`. An enclosing level can join them into a bidirectional pad.

The bus drivers are turned on only when both active-low output enables are low and the mode is not load. The enables only gate the drivers. They never affect the register itself.

An active-low clear empties the register at once, without waiting for the clock. It overrides every mode.

Top module: `usr_shift_reg`

## Requirements
- R1: With mode 2'b00 (hold) and clear inactive, a rising clock edge leaves the register contents unchanged.
- R2: With mode 2'b01 (shift toward high end), bit 0 takes `shr_in` and each bit i>0 takes the old bit i-1 on the rising edge.
- R3: With mode 2'b10 (shift toward low end), bit W-1 takes `shl_in` and each bit i<W-1 takes the old bit i+1 on the rising edge.
- R4: With mode 2'b11 (parallel load), the register captures `bus_in` on the rising edge.
- R5: While `clr_n` is low, the register is zero, independent of the clock. It goes to zero as soon as `clr_n` falls, even between edges, and it stays zero across clock edges that occur while `clr_n` is low, whatever the mode.
- R6: `bus_oe` is high exactly when `oe_a_n` and `oe_b_n` are both low and the mode is not 2'b11.
- R7: The output enables have no effect on shifting, loading, holding or clearing.
- R8: `bus_out` always equals the register contents, `low_out` equals bit 0 and `high_out` equals bit W-1, so all three read zero while clear is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| mode | input | 2 | 00 hold, 01 shift up, 10 shift down, 11 load |
| shr_in | input | 1 | Serial bit entering bit 0 on a shift up |
| shl_in | input | 1 | Serial bit entering bit W-1 on a shift down |
| oe_a_n | input | 1 | Bus output enable, active low |
| oe_b_n | input | 1 | Bus output enable, active low |
| bus_in | input | W | Parallel bus value sampled in load mode |
| bus_out | output | W | Register contents for the bus driver |
| bus_oe | output | 1 | Bus driver enable |
| low_out | output | 1 | Bit 0, always driven |
| high_out | output | 1 | Bit W-1, always driven |

## Verification
On every cycle, the assertions check three things. First, the next-state relation for each mode, comparing the register after an edge with the previous contents and serial or bus inputs. Second, that the register is zero whenever clear is sampled low. Third, that the driver enable and end-bit outputs agree with the mode, the enables and `bus_out`.

Some behaviour only the bench scenarios can show. One is a clear that lands between clock edges, checked before the next edge arrives. Another is that the enables are ignored, which is shown by repeating loads and shifts under every enable combination and comparing against a bench model.

// File: rtl/usr_pkg.sv
// Shared definitions for the universal shift register.
// Assumes the two-bit mode encoding listed in the brief.
package usr_pkg;

    typedef enum logic [1:0] {
        MODE_HOLD = 2'b00,
        MODE_UP   = 2'b01,
        MODE_DOWN = 2'b10,
        MODE_LOAD = 2'b11
    } usr_mode_e;

endpackage

// File: rtl/usr_next_state.sv
// Next-state selector: computes the register value that the coming
// rising edge will store, from the mode, serial inputs and bus value.
// Assumes W >= 2.
module usr_next_state #(
    parameter int W = 8
) (
    input  logic [W-1:0] cur,
    input  logic [1:0]   mode,
    input  logic         shr_in,
    input  logic         shl_in,
    input  logic [W-1:0] bus_in,
    output logic [W-1:0] nxt
);
    import usr_pkg::*;

    localparam int TOP = W - 1;

    logic [W-1:0] up_val;
    logic [W-1:0] down_val;

    // Build both shifted images bit by bit.
    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_shift
            if (i == 0) begin : g_lo
                assign up_val[i] = shr_in;
            end else begin : g_up
                assign up_val[i] = cur[i-1];
            end
            if (i == TOP) begin : g_hi
                assign down_val[i] = shl_in;
            end else begin : g_dn
                assign down_val[i] = cur[i+1];
            end
        end
    endgenerate

    // Choose the image that the selected mode asks for.
    always_comb begin
        unique case (usr_mode_e'(mode))
            MODE_HOLD: nxt = cur;
            MODE_UP:   nxt = up_val;
            MODE_DOWN: nxt = down_val;
            MODE_LOAD: nxt = bus_in;
            default:   nxt = cur;
        endcase
    end

endmodule

// File: rtl/usr_bus_ctrl.sv
// Bus driver control: turns the shared bus drivers on only when both
// active-low enables are low and the bus is not being read for a load.
// Assumes nothing beyond the mode encoding in usr_pkg.
module usr_bus_ctrl (
    input  logic [1:0] mode,
    input  logic       oe_a_n,
    input  logic       oe_b_n,
    output logic       bus_oe
);
    import usr_pkg::*;

    logic enables_low;
    logic loading;

    // Both enables must be low and the bus must not be an input.
    always_comb begin
        enables_low = !oe_a_n && !oe_b_n;
        loading     = (usr_mode_e'(mode) == MODE_LOAD);
        bus_oe      = enables_low && !loading;
    end

endmodule

// File: rtl/usr_shift_reg.sv
// Universal shift register with a split parallel bus (in, out, enable),
// two serial inputs, two always-driven end-bit outputs and an
// asynchronous active-low clear. Assumes W >= 2. The enables only gate
// the bus drivers and never the register.
module usr_shift_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic [1:0]   mode,
    input  logic         shr_in,
    input  logic         shl_in,
    input  logic         oe_a_n,
    input  logic         oe_b_n,
    input  logic [W-1:0] bus_in,
    output logic [W-1:0] bus_out,
    output logic         bus_oe,
    output logic         low_out,
    output logic         high_out
);
    localparam int TOP = W - 1;

    logic [W-1:0] state_q;
    logic [W-1:0] state_d;

    usr_next_state #(.W(W)) u_next (
        .cur    (state_q),
        .mode   (mode),
        .shr_in (shr_in),
        .shl_in (shl_in),
        .bus_in (bus_in),
        .nxt    (state_d)
    );

    usr_bus_ctrl u_bus (
        .mode   (mode),
        .oe_a_n (oe_a_n),
        .oe_b_n (oe_b_n),
        .bus_oe (bus_oe)
    );

    // Register: cleared at once by clr_n, otherwise updated on the edge.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    // Drive the parallel and serial outputs from the register.
    always_comb begin
        bus_out  = state_q;
        low_out  = state_q[0];
        high_out = state_q[TOP];
    end

endmodule

// File: rtl/usr_shift_reg_chk.sv
// Checker for usr_shift_reg: relates the outputs after each edge to the
// inputs and outputs before it. Attached to every instance by bind.
module usr_shift_reg_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         clr_n,
    input logic [1:0]   mode,
    input logic         shr_in,
    input logic         shl_in,
    input logic         oe_a_n,
    input logic         oe_b_n,
    input logic [W-1:0] bus_in,
    input logic [W-1:0] bus_out,
    input logic         bus_oe,
    input logic         low_out,
    input logic         high_out
);
    localparam int TOP = W - 1;

    // R1
    hold_keeps_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (mode == 2'b00) |=> $stable(bus_out));

    // R2
    shift_up_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (mode == 2'b01) |=> (bus_out == {$past(bus_out[TOP-1:0]), $past(shr_in)}));

    // R3
    shift_down_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (mode == 2'b10) |=> (bus_out == {$past(shl_in), $past(bus_out[TOP:1])}));

    // R4
    load_capture_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (mode == 2'b11) |=> (bus_out == $past(bus_in)));

    // R5
    clear_zero_chk: assert property (@(posedge clk)
        !clr_n |-> (bus_out == '0 && !low_out && !high_out));

    // R6
    load_float_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (mode == 2'b11) |-> !bus_oe);

    // R6
    enable_gate_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (oe_a_n || oe_b_n) |-> !bus_oe);

    // R8
    end_bits_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (low_out == bus_out[0]) && (high_out == bus_out[TOP]));

endmodule

bind usr_shift_reg usr_shift_reg_chk #(.W(W)) u_chk (.*);

// File: tb/usr_shift_reg_test.sv
// Self-checking bench: directed corners plus seeded random stimulus,
// compared against a bench model of the register.
module usr_shift_reg_test;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         clr_n = 1'b0;
    logic [1:0]   mode = 2'b00;
    logic         shr_in = 1'b0;
    logic         shl_in = 1'b0;
    logic         oe_a_n = 1'b1;
    logic         oe_b_n = 1'b1;
    logic [W-1:0] bus_in = '0;
    logic [W-1:0] bus_out;
    logic         bus_oe;
    logic         low_out;
    logic         high_out;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] model = '0;
    bit done = 1'b0;

    usr_shift_reg #(.W(W)) uut (.*);

    always #2.5 clk = ~clk;

    // Model of the register update for one edge.
    function automatic logic [W-1:0] next_val(input logic [W-1:0] cur,
            input logic [1:0] m, input logic sr, input logic sl,
            input logic [W-1:0] bi, input logic c);
        if (!c) return '0;
        case (m)
            2'b01:   return {cur[W-2:0], sr};
            2'b10:   return {sl, cur[W-1:1]};
            2'b11:   return bi;
            default: return cur;
        endcase
    endfunction

    // Model of the driver enable.
    function automatic logic oe_val(input logic [1:0] m, input logic a, input logic b);
        return !a && !b && (m != 2'b11);
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_outputs(input string req);
        check(bus_out == model, req, 32'(bus_out), 32'(model));
        check(low_out == model[0] && high_out == model[W-1], "R8",
              {30'd0, high_out, low_out}, {30'd0, model[W-1], model[0]});
        check(bus_oe == oe_val(mode, oe_a_n, oe_b_n), "R6",
              32'(bus_oe), 32'(oe_val(mode, oe_a_n, oe_b_n)));
    endtask

    // Drive inputs at a falling edge, then check just after the rising edge.
    task automatic cycle(input logic [1:0] m, input logic sr, input logic sl,
                         input logic a, input logic b, input logic [W-1:0] bi,
                         input logic c, input string req);
        @(negedge clk);
        mode = m; shr_in = sr; shl_in = sl; oe_a_n = a; oe_b_n = b;
        bus_in = bi; clr_n = c;
        #0.5;
        check(bus_oe == oe_val(m, a, b), "R6", 32'(bus_oe), 32'(oe_val(m, a, b)));
        @(posedge clk);
        model = next_val(model, m, sr, sl, bi, c);
        #1;
        check_outputs(req);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240613));
        // Reset state (R5, R8)
        #1;
        check(bus_out == '0, "R5", 32'(bus_out), 0);
        cycle(2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 8'hFF, 1'b0, "R5");
        // Load and hold (R4, R1)
        cycle(2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5, 1'b1, "R4");
        cycle(2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1, "R1");
        cycle(2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 8'hFF, 1'b1, "R1");
        // Shift a one through every position both ways (R2, R3)
        cycle(2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, "R4");
        cycle(2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, "R2");
        for (int k = 0; k < W; k++) cycle(2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1, "R2");
        cycle(2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1, "R3");
        for (int k = 0; k < W; k++) cycle(2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, "R3");
        // Enables high must not stop load or shift (R7)
        cycle(2'b11, 1'b0, 1'b0, 1'b1, 1'b1, 8'h3C, 1'b1, "R7");
        cycle(2'b01, 1'b1, 1'b0, 1'b0, 1'b1, 8'h00, 1'b1, "R7");
        cycle(2'b10, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b1, "R7");
        // Clear between edges, seen before the next edge (R5)
        @(negedge clk);
        mode = 2'b00;
        #1 clr_n = 1'b0;
        #0.5;
        model = '0;
        check(bus_out == '0, "R5", 32'(bus_out), 0);
        check(low_out == 1'b0 && high_out == 1'b0, "R8", {30'd0, high_out, low_out}, 0);
        cycle(2'b11, 1'b1, 1'b1, 1'b1, 1'b1, 8'hFF, 1'b0, "R5");
        cycle(2'b01, 1'b1, 1'b1, 1'b0, 1'b0, 8'hFF, 1'b0, "R5");
        // Seeded random mix (all requirements)
        for (int n = 0; n < 600; n++) begin
            logic [1:0] m;
            logic c;
            m = 2'($urandom);
            c = ($urandom % 20) != 0;
            cycle(m, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                  8'($urandom), c, (m == 2'b00) ? "R1" : (m == 2'b01) ? "R2" :
                  (m == 2'b10) ? "R3" : "R4");
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule